// File: doc/BRIEF.md
# Interrupt Coalescing Controller for a Network Interface

This block sits between the transmit and receive datapaths of a network interface and the register that latches interrupt causes. Each transmit-completion or receive event brings a set of cause bits. The block decides whether those bits reach the cause register at once or are held and merged with later events into one deferred interrupt. The aim is fewer interrupts under load, while the first events of a burst and any event that signals a nearly full ring are still reported without delay.

Transmit requests pass through a gate. Early requests and requests that would bring the ring close to full go through to the descriptor engine. Other requests are held back until a flush. A single flush timer, programmed in 1024 ns ticks, starts when the first deferred event arrives. When the timer runs out, everything held is delivered and a transmit kick restarts the held transmit work. A delay of zero turns deferral off.

Top module: `irq_coalesce`

## Requirements
- R1: A synchronous reset clears the transmit and receive event counts, the held cause word and the flush timer. After reset, `cause_set`, `tx_go` and `tx_kick` are low, and `cause_word` is zero in every cycle in which `cause_set` is low.
- R2: The ring holds `tx_len_bytes / DESC_BYTES` entries. The pending descriptor count is `tx_tail - tx_head`, with the entry count added when tail is below head. The near-full limit is the entry count minus `HEADROOM` (5), or zero if that would be negative.
- R3: A `tx_req` gets a one-cycle `tx_go` pulse in the next cycle, except when the transmit count is above `EARLY_EVENTS` (4) and the transmit count plus pending is below the near-full limit. An accepted request latches the pending count.
- R4: All cause bits from transmit and receive events are ORed into a held word. A delivery presents the OR of every cause received since the previous delivery.
- R5: On `tx_done`, the latched pending count is added to the transmit count. If the sum reaches the near-full limit, the held causes are delivered in the next cycle and the transmit count clears. Otherwise the flush timer is armed.
- R6: A receive event arriving while the receive count is zero is delivered in the next cycle and sets the receive count to one.
- R7: A receive event with bit 4 of `rx_cause` set (descriptor low threshold), arriving while the receive count is below 100000, is delivered at once and sets the receive count to 100000. Later low-threshold events are deferred until a flush clears the count.
- R8: Any other receive event increments the receive count (saturating) and arms the flush timer.
- R9: An armed timer fires `delay_ticks * CLKS_PER_TICK` cycles after the first deferred event. Arming again while it runs does not restart it. On firing, if either count is nonzero, `cause_set` and `tx_kick` pulse together and both counts clear. If both counts are zero, nothing is signalled.
- R10: When `delay_ticks` is zero, every transmit-done and receive event is delivered in the next cycle, and every `tx_req` is accepted.
- R11: An immediate delivery cancels a running flush timer, so no flush follows it unless a new deferred event arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_head | input | IDX_W | Transmit ring head index |
| tx_tail | input | IDX_W | Transmit ring tail index |
| tx_len_bytes | input | IDX_W+1+log2(DESC_BYTES) | Transmit ring size in bytes |
| tx_req | input | 1 | Software asks for transmit processing |
| tx_done | input | 1 | Transmit processing finished, causes on tx_cause |
| tx_cause | input | CAUSE_W | Cause bits of the transmit-done event |
| rx_evt | input | 1 | Receive event, causes on rx_cause |
| rx_cause | input | CAUSE_W | Cause bits of the receive event, bit 4 is the low-threshold flag |
| delay_ticks | input | DLY_W | Flush delay in 1024 ns ticks, zero disables deferral |
| tx_go | output | 1 | Pulse: descriptor engine may process the ring |
| tx_kick | output | 1 | Pulse: flush restarts held transmit work |
| cause_set | output | 1 | Pulse: write cause_word into the cause register |
| cause_word | output | CAUSE_W | Merged cause bits delivered |

## Verification
The embedded properties check, on every cycle, that a first receive event and any event under zero delay produce a delivery in the next cycle. They also check that a kick never appears without a delivery, that the cause word is silent between deliveries, that an early transmit request is always accepted, and that arming a running timer leaves its remaining count untouched. The directed scenarios are needed for the behaviours that depend on history and timing. These are the exact flush cycle and the merged word, the wrap-around pending computation that decides the gating, the one-shot nature of the low-threshold bypass, the cancellation of the timer by an early delivery, and the silent expiry when both counts are zero.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   // Reason for a delivery in the current cycle, in priority order
   typedef enum logic [2:0] {
      DLV_NONE,
      DLV_FLUSH,
      DLV_ZERO,
      DLV_TX_FULL,
      DLV_RX_FIRST,
      DLV_RX_LOW
   } deliv_t;

endpackage

// File: rtl/irqc_ring_calc.sv
module irqc_ring_calc #(
   parameter int IDX_W      = 8,
   parameter int DESC_BYTES = 16,
   parameter int HEADROOM   = 5,
   localparam int DESC_SH   = $clog2(DESC_BYTES),
   localparam int ENT_W     = IDX_W + 1,
   localparam int LEN_W     = ENT_W + DESC_SH
) (
   input  logic [IDX_W-1:0] head,
   input  logic [IDX_W-1:0] tail,
   input  logic [LEN_W-1:0] len_bytes,
   output logic [ENT_W-1:0] pending,
   output logic [ENT_W-1:0] limit
);

   logic [ENT_W-1:0] entries;
   logic [ENT_W-1:0] head_x;
   logic [ENT_W-1:0] tail_x;

   always_comb begin
      entries = ENT_W'(len_bytes >> DESC_SH);
      head_x  = ENT_W'(head);
      tail_x  = ENT_W'(tail);
      // occupancy with wrap-around of the ring indices
      if (tail_x >= head_x) pending = tail_x - head_x;
      else                  pending = tail_x + entries - head_x;
      // near-full limit, floored at zero for tiny rings
      if (entries > ENT_W'(HEADROOM)) limit = entries - ENT_W'(HEADROOM);
      else                            limit = '0;
   end

endmodule

// File: rtl/irqc_flush_timer.sv
module irqc_flush_timer #(
   parameter int DLY_W         = 16,
   parameter int CLKS_PER_TICK = 128
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             arm,
   input  logic             cancel,
   input  logic [DLY_W-1:0] delay,
   output logic             running,
   output logic             expire
);

   logic             run_q;
   logic [DLY_W-1:0] rem_q;
   logic             tick;
   logic             start;

   assign start = arm && !run_q && !cancel && (delay != '0);

   generate
      if (CLKS_PER_TICK < 1) begin : g_bad_tick
         $error("CLKS_PER_TICK must be at least 1");
      end
      if (CLKS_PER_TICK == 1) begin : g_no_pre
         assign tick = run_q;
      end else begin : g_pre
         localparam int PRE_W = $clog2(CLKS_PER_TICK);
         localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_TICK - 1);
         logic [PRE_W-1:0] pre_q;
         always_ff @(posedge clk) begin
            if (rst || start)  pre_q <= '0;
            else if (run_q)    pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
         end
         assign tick = run_q && (pre_q == PRE_LAST);
      end
   endgenerate

   assign expire  = tick && (rem_q == DLY_W'(1));
   assign running = run_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         run_q <= 1'b0;
         rem_q <= '0;
      end else if (cancel || expire) begin
         run_q <= 1'b0;
      end else if (start) begin
         run_q <= 1'b1;
         rem_q <= delay;
      end else if (tick) begin
         rem_q <= rem_q - 1'b1;
      end
   end

   // R9
   arm_no_restart_chk: assert property (@(posedge clk) disable iff (rst)
      (run_q && arm && !cancel && !tick) |=> (rem_q == $past(rem_q)));

endmodule

// File: rtl/irqc_tx_gate.sv
module irqc_tx_gate #(
   parameter int ENT_W        = 9,
   parameter int TXC_W        = 10,
   parameter int EARLY_EVENTS = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tx_req,
   input  logic             tx_done,
   input  logic             zero_dly,
   input  logic [TXC_W-1:0] tx_cnt,
   input  logic [ENT_W-1:0] pending,
   input  logic [ENT_W-1:0] limit,
   output logic             tx_go,
   output logic [ENT_W-1:0] pend_q
);

   localparam int SUM_W = TXC_W + 1;

   logic [SUM_W-1:0] look_sum;
   logic             hold_back;

   generate
      if (EARLY_EVENTS >= (1 << TXC_W)) begin : g_bad_early
         $error("EARLY_EVENTS does not fit the transmit counter");
      end
   endgenerate

   always_comb begin
      look_sum  = SUM_W'(tx_cnt) + SUM_W'(pending);
      hold_back = !zero_dly
                  && (tx_cnt > TXC_W'(EARLY_EVENTS))
                  && (look_sum < SUM_W'(limit));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         tx_go  <= 1'b0;
         pend_q <= '0;
      end else begin
         tx_go <= tx_req && !hold_back;
         if (tx_req && !hold_back) pend_q <= pending;
         else if (tx_done)         pend_q <= '0;
      end
   end

   // R3
   early_accept_chk: assert property (@(posedge clk) disable iff (rst)
      (tx_req && (tx_cnt <= TXC_W'(EARLY_EVENTS))) |=> tx_go);

endmodule

// File: rtl/irq_coalesce.sv
module irq_coalesce #(
   parameter int IDX_W         = 8,
   parameter int DESC_BYTES    = 16,
   parameter int CAUSE_W       = 16,
   parameter int DLY_W         = 16,
   parameter int CLKS_PER_TICK = 128,
   parameter int EARLY_EVENTS  = 4,
   parameter int HEADROOM      = 5,
   parameter int RX_SENTINEL   = 100000,
   parameter int LOWTHR_BIT    = 4,
   localparam int DESC_SH      = $clog2(DESC_BYTES),
   localparam int ENT_W        = IDX_W + 1,
   localparam int LEN_W        = ENT_W + DESC_SH
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [IDX_W-1:0]   tx_head,
   input  logic [IDX_W-1:0]   tx_tail,
   input  logic [LEN_W-1:0]   tx_len_bytes,
   input  logic               tx_req,
   input  logic               tx_done,
   input  logic [CAUSE_W-1:0] tx_cause,
   input  logic               rx_evt,
   input  logic [CAUSE_W-1:0] rx_cause,
   input  logic [DLY_W-1:0]   delay_ticks,
   output logic               tx_go,
   output logic               tx_kick,
   output logic               cause_set,
   output logic [CAUSE_W-1:0] cause_word
);
   import irqc_pkg::*;

   localparam int TXC_W = ENT_W + 1;
   localparam int RXC_W = $clog2(RX_SENTINEL + 1);
   localparam int SUM_W = TXC_W + 1;
   localparam logic [RXC_W-1:0] RX_SENT = RXC_W'(RX_SENTINEL);

   generate
      if ((1 << DESC_SH) != DESC_BYTES) begin : g_bad_desc
         $error("DESC_BYTES must be a power of two");
      end
      if (LOWTHR_BIT >= CAUSE_W) begin : g_bad_bit
         $error("LOWTHR_BIT outside the cause word");
      end
   endgenerate

   // ring occupancy
   logic [ENT_W-1:0] pending;
   logic [ENT_W-1:0] limit;

   irqc_ring_calc #(
      .IDX_W      (IDX_W),
      .DESC_BYTES (DESC_BYTES),
      .HEADROOM   (HEADROOM)
   ) u_ring (
      .head      (tx_head),
      .tail      (tx_tail),
      .len_bytes (tx_len_bytes),
      .pending   (pending),
      .limit     (limit)
   );

   // state
   logic [TXC_W-1:0]   tx_cnt;
   logic [RXC_W-1:0]   rx_cnt;
   logic [CAUSE_W-1:0] held;
   logic [ENT_W-1:0]   pend_q;
   logic               zero_dly;

   assign zero_dly = (delay_ticks == '0);

   irqc_tx_gate #(
      .ENT_W        (ENT_W),
      .TXC_W        (TXC_W),
      .EARLY_EVENTS (EARLY_EVENTS)
   ) u_gate (
      .clk      (clk),
      .rst      (rst),
      .tx_req   (tx_req),
      .tx_done  (tx_done),
      .zero_dly (zero_dly),
      .tx_cnt   (tx_cnt),
      .pending  (pending),
      .limit    (limit),
      .tx_go    (tx_go),
      .pend_q   (pend_q)
   );

   // flush timer
   logic arm;
   logic deliver;
   logic tmr_running;
   logic tmr_expire;

   irqc_flush_timer #(
      .DLY_W         (DLY_W),
      .CLKS_PER_TICK (CLKS_PER_TICK)
   ) u_timer (
      .clk     (clk),
      .rst     (rst),
      .arm     (arm),
      .cancel  (deliver),
      .delay   (delay_ticks),
      .running (tmr_running),
      .expire  (tmr_expire)
   );

   // decision logic
   logic [SUM_W-1:0]   tx_sum_raw;
   logic [TXC_W-1:0]   tx_sum;
   logic               tx_full;
   logic               rx_first;
   logic               rx_low;
   logic               flush_go;
   logic               any_evt;
   logic [CAUSE_W-1:0] merged;
   deliv_t             reason;
   logic [TXC_W-1:0]   tx_cnt_nxt;
   logic [RXC_W-1:0]   rx_cnt_nxt;

   always_comb begin
      tx_sum_raw = SUM_W'(tx_cnt) + SUM_W'(pend_q);
      tx_sum     = tx_sum_raw[SUM_W-1] ? '1 : tx_sum_raw[TXC_W-1:0];
      tx_full    = tx_done && (tx_sum >= TXC_W'(limit));
      rx_first   = rx_evt && (rx_cnt == '0);
      rx_low     = rx_evt && !rx_first && rx_cause[LOWTHR_BIT] && (rx_cnt < RX_SENT);
      flush_go   = tmr_expire && ((tx_cnt != '0) || (rx_cnt != '0));
      any_evt    = tx_done || rx_evt;
      merged     = held | (tx_done ? tx_cause : '0) | (rx_evt ? rx_cause : '0);

      if (flush_go)                 reason = DLV_FLUSH;
      else if (zero_dly && any_evt) reason = DLV_ZERO;
      else if (tx_full)             reason = DLV_TX_FULL;
      else if (rx_first)            reason = DLV_RX_FIRST;
      else if (rx_low)              reason = DLV_RX_LOW;
      else                          reason = DLV_NONE;

      deliver = (reason != DLV_NONE);
      arm     = !deliver && any_evt;

      case (reason)
         DLV_FLUSH, DLV_ZERO: begin
            tx_cnt_nxt = '0;
            rx_cnt_nxt = '0;
         end
         default: begin
            if (tx_full)      tx_cnt_nxt = '0;
            else if (tx_done) tx_cnt_nxt = tx_sum;
            else              tx_cnt_nxt = tx_cnt;

            if (rx_first)                      rx_cnt_nxt = RXC_W'(1);
            else if (rx_low)                   rx_cnt_nxt = RX_SENT;
            else if (rx_evt && (rx_cnt != '1)) rx_cnt_nxt = rx_cnt + 1'b1;
            else                               rx_cnt_nxt = rx_cnt;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         tx_cnt     <= '0;
         rx_cnt     <= '0;
         held       <= '0;
         cause_set  <= 1'b0;
         cause_word <= '0;
         tx_kick    <= 1'b0;
      end else begin
         tx_cnt     <= tx_cnt_nxt;
         rx_cnt     <= rx_cnt_nxt;
         held       <= deliver ? '0 : merged;
         cause_set  <= deliver;
         cause_word <= deliver ? merged : '0;
         tx_kick    <= (reason == DLV_FLUSH);
      end
   end

   // R6
   rx_first_chk: assert property (@(posedge clk) disable iff (rst)
      (rx_evt && (rx_cnt == '0)) |=> cause_set);

   // R10
   zero_delay_chk: assert property (@(posedge clk) disable iff (rst)
      ((delay_ticks == '0) && (tx_done || rx_evt)) |=> cause_set);

   // R9
   kick_with_cause_chk: assert property (@(posedge clk) disable iff (rst)
      tx_kick |-> cause_set);

   // R1
   quiet_word_chk: assert property (@(posedge clk) disable iff (rst)
      !cause_set |-> (cause_word == '0));

   // R11
   cancel_on_deliver_chk: assert property (@(posedge clk) disable iff (rst)
      (deliver && !arm) |=> !tmr_running);

endmodule

// File: tb/tb_irq_coalesce.sv
module tb_irq_coalesce;

   localparam int CLK_PERIOD = 10;
   localparam int IDX_W      = 8;
   localparam int CAUSE_W    = 16;
   localparam int DLY_W      = 16;
   localparam int CPT        = 4;
   localparam int LEN_W      = IDX_W + 1 + 4;
   localparam int DLY        = 3;
   localparam int FIRE       = DLY * CPT;

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic [IDX_W-1:0]   tx_head = '0;
   logic [IDX_W-1:0]   tx_tail = '0;
   logic [LEN_W-1:0]   tx_len_bytes = LEN_W'(1024);
   logic               tx_req = 1'b0;
   logic               tx_done = 1'b0;
   logic [CAUSE_W-1:0] tx_cause = '0;
   logic               rx_evt = 1'b0;
   logic [CAUSE_W-1:0] rx_cause = '0;
   logic [DLY_W-1:0]   delay_ticks = DLY_W'(DLY);
   logic               tx_go;
   logic               tx_kick;
   logic               cause_set;
   logic [CAUSE_W-1:0] cause_word;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   irq_coalesce #(
      .IDX_W         (IDX_W),
      .CAUSE_W       (CAUSE_W),
      .DLY_W         (DLY_W),
      .CLKS_PER_TICK (CPT)
   ) dut (
      .clk          (clk),
      .rst          (rst),
      .tx_head      (tx_head),
      .tx_tail      (tx_tail),
      .tx_len_bytes (tx_len_bytes),
      .tx_req       (tx_req),
      .tx_done      (tx_done),
      .tx_cause     (tx_cause),
      .rx_evt       (rx_evt),
      .rx_cause     (rx_cause),
      .delay_ticks  (delay_ticks),
      .tx_go        (tx_go),
      .tx_kick      (tx_kick),
      .cause_set    (cause_set),
      .cause_word   (cause_word)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; tx_req = 0; tx_done = 0; rx_evt = 0;
      delay_ticks = DLY_W'(DLY);
      tx_len_bytes = LEN_W'(1024);
      repeat (2) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic pulse_rx(input int c);
      rx_cause = CAUSE_W'(c); rx_evt = 1'b1;
      @(posedge clk); @(negedge clk);
      rx_evt = 1'b0;
   endtask

   task automatic pulse_txreq();
      tx_req = 1'b1;
      @(posedge clk); @(negedge clk);
      tx_req = 1'b0;
   endtask

   task automatic pulse_txdone(input int c);
      tx_cause = CAUSE_W'(c); tx_done = 1'b1;
      @(posedge clk); @(negedge clk);
      tx_done = 1'b0;
   endtask

   task automatic expect_now(input int word, input string tag);
      chk(cause_set === 1'b1, {tag, " cause_set"}, int'(cause_set), 1);
      chk(cause_word === CAUSE_W'(word), {tag, " cause_word"}, int'(cause_word), word);
      chk(tx_kick === 1'b0, {tag, " no kick"}, int'(tx_kick), 0);
   endtask

   task automatic expect_held(input string tag);
      chk(cause_set === 1'b0, {tag, " deferred"}, int'(cause_set), 0);
   endtask

   task automatic check_quiet(input int n, input string tag);
      int seen = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (cause_set !== 1'b0 || tx_kick !== 1'b0) seen++;
      end
      chk(seen == 0, {tag, " quiet window"}, seen, 0);
   endtask

   task automatic expect_fire(input int n, input int word, input string tag);
      int early = 0;
      for (int i = 1; i < n; i++) begin
         @(negedge clk);
         if (cause_set !== 1'b0) early++;
      end
      chk(early == 0, {tag, " no early flush"}, early, 0);
      @(negedge clk);
      chk(cause_set === 1'b1, {tag, " flush cause_set"}, int'(cause_set), 1);
      chk(cause_word === CAUSE_W'(word), {tag, " flush word"}, int'(cause_word), word);
      chk(tx_kick === 1'b1, {tag, " flush kick"}, int'(tx_kick), 1);
   endtask

   // R1: reset state
   task automatic t_reset();
      do_reset();
      chk(cause_set === 1'b0, "R1 cause_set after reset", int'(cause_set), 0);
      chk(tx_go === 1'b0, "R1 tx_go after reset", int'(tx_go), 0);
      chk(tx_kick === 1'b0, "R1 tx_kick after reset", int'(tx_kick), 0);
      chk(cause_word === '0, "R1 cause_word after reset", int'(cause_word), 0);
   endtask

   // R6, R8, R9, R4: first immediate, later merged into one flush
   task automatic t_rx_flush();
      do_reset();
      pulse_rx('h0001);
      expect_now('h0001, "R6 first rx");
      pulse_rx('h0002);
      expect_held("R8 second rx");
      check_quiet(3, "R8 before re-arm");
      pulse_rx('h0008);
      expect_held("R8 third rx");
      expect_fire(FIRE - 4, 'h000A, "R9 R4 merged flush no restart");
      pulse_rx('h0020);
      expect_now('h0020, "R9 counts cleared by flush");
   endtask

   // R7, R11: low-threshold bypass once, cancels timer
   task automatic t_rx_low();
      do_reset();
      pulse_rx('h0001);
      expect_now('h0001, "R6 first rx");
      pulse_rx('h0002);
      expect_held("R8 deferred rx");
      check_quiet(2, "R8 wait");
      pulse_rx('h0010);
      expect_now('h0012, "R7 low threshold immediate");
      check_quiet(FIRE + 8, "R11 timer cancelled");
      pulse_rx('h0010);
      expect_held("R7 second low threshold deferred");
      expect_fire(FIRE, 'h0010, "R7 low threshold via flush");
   endtask

   // R2, R3, R5, R11: transmit gating with wrap-around
   task automatic t_tx_gate();
      do_reset();
      tx_head = IDX_W'(0); tx_tail = IDX_W'(10);
      pulse_txreq();
      chk(tx_go === 1'b1, "R3 early tx_req accepted", int'(tx_go), 1);
      pulse_txdone('h0100);
      expect_held("R5 tx below limit deferred");
      pulse_txreq();
      chk(tx_go === 1'b0, "R3 tx_req held back", int'(tx_go), 0);
      tx_head = IDX_W'(60); tx_tail = IDX_W'(50);
      pulse_txreq();
      chk(tx_go === 1'b1, "R2 wrapped pending reaches limit", int'(tx_go), 1);
      pulse_txdone('h0200);
      expect_now('h0300, "R5 tx near full immediate");
      check_quiet(FIRE + 8, "R11 no flush after tx delivery");
   endtask

   // R9, R4: expiry with empty counts stays silent, causes remain held
   task automatic t_empty_flush();
      do_reset();
      tx_head = IDX_W'(5); tx_tail = IDX_W'(5);
      pulse_txreq();
      chk(tx_go === 1'b1, "R3 tx_req accepted", int'(tx_go), 1);
      pulse_txdone('h0400);
      expect_held("R5 zero pending deferred");
      check_quiet(FIRE + 8, "R9 empty expiry silent");
      pulse_rx('h0001);
      expect_now('h0401, "R4 held cause survives");
   endtask

   // R10: zero delay disables deferral
   task automatic t_zero_delay();
      do_reset();
      delay_ticks = '0;
      pulse_rx('h0001);
      expect_now('h0001, "R10 rx 1");
      pulse_rx('h0002);
      expect_now('h0002, "R10 rx 2");
      tx_head = IDX_W'(0); tx_tail = IDX_W'(3);
      pulse_txreq();
      chk(tx_go === 1'b1, "R10 tx_req accepted", int'(tx_go), 1);
      pulse_txdone('h0100);
      expect_now('h0100, "R10 tx done");
      check_quiet(20, "R10 nothing deferred");
   endtask

   initial begin
      t_reset();
      t_rx_flush();
      t_rx_low();
      t_tx_gate();
      t_empty_flush();
      t_zero_delay();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule